// File: doc/BRIEF.md
# Multi-view GPIO port register block

This block holds the output latches, direction bits and mask bits for eight 32-bit general-purpose I/O ports and exposes them to a simple memory-mapped bus through several overlapping views. A single pin can be reached through its own byte-wide alias, where only bit 0 carries meaning, or through its own word-wide alias, which reads as all zeros or all ones. Whole ports can be read and written directly, through a mask that shields selected bits, or changed atomically with write-only set, clear and invert registers.

The pin inputs arrive already synchronised. Reading a pin gives the output latch when the pin is an output and the live input when it is an input. The block drives an output-data vector and an output-enable vector toward the pad ring. Writes take effect on the clock edge that accepts them. Reads are answered one cycle later by a two-state response machine: IDLE (no response pending) and RESP (read data on the bus). Both states move to RESP when a read is accepted and to IDLE otherwise.

Top module: `gpio_multiview`

## Requirements
- R1: After reset every output latch, direction bit and mask bit is 0, so `gpio_out` and `gpio_oe` are all zero and `rsp_valid` is low.
- R2: A read (`cmd_valid`=1, `cmd_write`=0) moves the response machine to RESP, so `rsp_valid` is high in the next cycle with the data. In any cycle without an accepted read the machine goes to IDLE, and in the following cycle `rsp_valid` is low and `rsp_rdata` is zero. A write changes `gpio_out`/`gpio_oe` in the cycle after it is accepted.
- R3: The direction register of port p is at 0x2000+4p. Bit n set to 1 makes pin n an output, and `gpio_oe[32p+n]` equals that bit.
- R4: The pin level of pin n is its output latch when the direction bit is 1 and `gpio_in[32p+n]` when it is 0. Every pin read returns this level.
- R5: The port register at 0x2100+4p reads all 32 pin levels. A write replaces all 32 output latches, including those of input pins.
- R6: The byte alias of pin n of port p is at 32p+n. A read returns the pin level in bit 0 and zeros in bits 31:1. A write loads bit 0 of the data into that pin's output latch.
- R7: The word alias of pin n of port p is at 0x1000+128p+4n. A read returns 0x00000000 or 0xFFFFFFFF according to the pin level. A write of any non-zero value sets the latch and a write of zero clears it.
- R8: The mask register at 0x2080+4p can be read back. A mask bit of 0 makes the pin active. The masked port register at 0x2180+4p reads the pin levels with inactive bits forced to 0. A write to it changes only the output latches of active pins.
- R9: At 0x2200+4p, 0x2280+4p and 0x2300+4p, every data bit that is 1 sets, clears or inverts the matching output latch. Data bits that are 0 leave their latch unchanged.
- R10: The set, clear and invert registers read as zero.
- R11: Any other address reads as zero and ignores writes. This includes word-view and port-view addresses with a non-zero address[1:0], and offsets 0x20..0x7F inside each 0x80-wide port-register group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Bus command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 14 | Byte address of the access |
| cmd_wdata | input | 32 | Write data |
| gpio_in | input | 256 | Synchronised pin inputs, port p at bits 32p+31..32p |
| gpio_out | output | 256 | Output latches |
| gpio_oe | output | 256 | Output enables (direction bits) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero when not valid |

## Verification
Directed sequences first set pins up as mixed inputs and outputs. Reading them through every view then separates the latch from the live input, and the byte and word aliases from the whole-port views. Masked writes with all-ones data against a half mask show whether inactive bits are protected. Set, clear and invert writes with sparse data show whether zero bits leave their latches alone. Unaligned addresses, gap addresses and addresses past the last group are probed to catch decode aliasing. A long pseudo-random mix of all views, with the inputs changing during the run, is compared on every clock against a behavioural model, which exposes ordering and read-latency faults.

// File: rtl/gpio_mv_pkg.sv
package gpio_mv_pkg;
    localparam int unsigned BUS_ADDR_W = 14;
    localparam int unsigned PORT_FLD_W = 3;
    localparam int unsigned PIN_FLD_W  = 5;

    typedef enum logic [3:0] {
        VIEW_NONE,
        VIEW_BYTE,
        VIEW_WORD,
        VIEW_DIR,
        VIEW_MASK,
        VIEW_PORT,
        VIEW_MPORT,
        VIEW_SET,
        VIEW_CLR,
        VIEW_TGL
    } view_e;

    typedef struct packed {
        view_e                 view;
        logic [PORT_FLD_W-1:0] port;
        logic [PIN_FLD_W-1:0]  pin;
    } acc_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_st_e;
endpackage

// File: rtl/gpio_mv_decode.sv
module gpio_mv_decode
    import gpio_mv_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8
) (
    input  logic [BUS_ADDR_W-1:0] addr,
    output acc_t                  acc
);
    always_comb begin
        acc = '{view: VIEW_NONE, port: '0, pin: '0};
        if (addr[13:8] == 6'd0) begin
            acc.view = VIEW_BYTE;
            acc.port = addr[7:5];
            acc.pin  = addr[4:0];
        end else if (addr[13:10] == 4'b0100 && addr[1:0] == 2'b00) begin
            acc.view = VIEW_WORD;
            acc.port = addr[9:7];
            acc.pin  = addr[6:2];
        end else if (addr[13:10] == 4'b1000 && addr[6:5] == 2'b00 && addr[1:0] == 2'b00) begin
            acc.port = addr[4:2];
            unique case (addr[9:7])
                3'd0:    acc.view = VIEW_DIR;
                3'd1:    acc.view = VIEW_MASK;
                3'd2:    acc.view = VIEW_PORT;
                3'd3:    acc.view = VIEW_MPORT;
                3'd4:    acc.view = VIEW_SET;
                3'd5:    acc.view = VIEW_CLR;
                3'd6:    acc.view = VIEW_TGL;
                default: acc.view = VIEW_NONE;
            endcase
        end
        if (32'(acc.port) >= NUM_PORTS) begin
            acc.view = VIEW_NONE;
        end
    end
endmodule

// File: rtl/gpio_mv_bank.sv
module gpio_mv_bank
    import gpio_mv_pkg::*;
#(
    parameter int unsigned PORT_W = 32,
    localparam int unsigned PIN_W = $clog2(PORT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  view_e             view,
    input  logic [PIN_W-1:0]  pin,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] mask_q,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] rd_view
);
    logic [PORT_W-1:0] level;

    assign level = (dir_q & out_q) | (~dir_q & pin_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            mask_q <= '0;
            out_q  <= '0;
        end else if (wr_en) begin
            unique case (view)
                VIEW_BYTE:  out_q[pin] <= wdata[0];
                VIEW_WORD:  out_q[pin] <= |wdata;
                VIEW_DIR:   dir_q      <= wdata;
                VIEW_MASK:  mask_q     <= wdata;
                VIEW_PORT:  out_q      <= wdata;
                VIEW_MPORT: out_q      <= (out_q & mask_q) | (wdata & ~mask_q);
                VIEW_SET:   out_q      <= out_q | wdata;
                VIEW_CLR:   out_q      <= out_q & ~wdata;
                VIEW_TGL:   out_q      <= out_q ^ wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_view = '0;
        unique case (view)
            VIEW_BYTE:  rd_view[0] = level[pin];
            VIEW_WORD:  rd_view    = {PORT_W{level[pin]}};
            VIEW_DIR:   rd_view    = dir_q;
            VIEW_MASK:  rd_view    = mask_q;
            VIEW_PORT:  rd_view    = level;
            VIEW_MPORT: rd_view    = level & ~mask_q;
            default:    rd_view    = '0;
        endcase
    end

    // R9
    set_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));
    // R9
    clr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_CLR) |=> ((out_q & $past(wdata)) == '0));
    // R9
    set_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_SET) |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
    // R8
    mport_shield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_MPORT) |=> ((out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q))));
    // R7
    word_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_WORD && wdata != '0) |=> out_q[$past(pin)]);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)));
endmodule

// File: rtl/gpio_mv_bus.sv
module gpio_mv_bus
    import gpio_mv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_value,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    bus_st_e state_q;
    bus_st_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_value;
        else             rsp_rdata <= '0;
    end

    assign rsp_valid = (state_q == ST_RESP);

    // R2
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    // R2
    no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rsp_valid && rsp_rdata == '0));
endmodule

// File: rtl/gpio_multiview.sv
module gpio_multiview
    import gpio_mv_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8,
    parameter int unsigned PORT_W    = 32,
    localparam int unsigned PIN_W    = $clog2(PORT_W),
    localparam int unsigned ALL_W    = NUM_PORTS * PORT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  cmd_write,
    input  logic [BUS_ADDR_W-1:0] cmd_addr,
    input  logic [PORT_W-1:0]     cmd_wdata,
    input  logic [ALL_W-1:0]      gpio_in,
    output logic [ALL_W-1:0]      gpio_out,
    output logic [ALL_W-1:0]      gpio_oe,
    output logic                  rsp_valid,
    output logic [PORT_W-1:0]     rsp_rdata
);
    acc_t              acc;
    logic [PORT_W-1:0] bank_rd [NUM_PORTS];
    logic [PORT_W-1:0] rd_value;
    logic              rd_req;

    gpio_mv_decode #(.NUM_PORTS(NUM_PORTS)) u_decode (
        .addr (cmd_addr),
        .acc  (acc)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_sel;
        assign wr_sel = cmd_valid && cmd_write && (acc.view != VIEW_NONE)
                        && (32'(acc.port) == p);
        gpio_mv_bank #(.PORT_W(PORT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel),
            .view    (acc.view),
            .pin     (acc.pin[PIN_W-1:0]),
            .wdata   (cmd_wdata),
            .pin_in  (gpio_in[p*PORT_W +: PORT_W]),
            .dir_q   (gpio_oe[p*PORT_W +: PORT_W]),
            .mask_q  (),
            .out_q   (gpio_out[p*PORT_W +: PORT_W]),
            .rd_view (bank_rd[p])
        );
    end

    assign rd_req   = cmd_valid && !cmd_write;
    assign rd_value = (acc.view == VIEW_NONE) ? '0 : bank_rd[acc.port];

    gpio_mv_bus #(.DATA_W(PORT_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_value  (rd_value),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R10
    strobe_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (acc.view == VIEW_SET || acc.view == VIEW_CLR || acc.view == VIEW_TGL))
        |=> (rsp_rdata == '0));
    // R6
    byte_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc.view == VIEW_BYTE) |=> (rsp_rdata[PORT_W-1:1] == '0));
    // R7
    word_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc.view == VIEW_WORD) |=> (rsp_rdata == '0 || rsp_rdata == '1));
    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc.view == VIEW_NONE) |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_gpio_multiview.sv
`timescale 1ns/100ps
module tb_gpio_multiview;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_write = 1'b0;
    logic [13:0]  cmd_addr = '0;
    logic [31:0]  cmd_wdata = '0;
    logic [255:0] gpio_in = '0;
    logic [255:0] gpio_out;
    logic [255:0] gpio_oe;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_out  [8];
    logic [31:0] m_dir  [8];
    logic [31:0] m_mask [8];

    always #2.5 clk = ~clk;

    gpio_multiview dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lvl(input int p);
        return (m_dir[p] & m_out[p]) | (~m_dir[p] & gpio_in[p*32 +: 32]);
    endfunction

    // kinds: 0 none, 1 byte, 2 word, 3 dir, 4 mask, 5 port, 6 masked, 7 set, 8 clr, 9 invert
    task automatic bdecode(input int a, output int k, output int p, output int n);
        k = 0; p = 0; n = 0;
        if (a < 256) begin
            k = 1; p = a / 32; n = a % 32;
        end else if (a >= 4096 && a < 5120 && a % 4 == 0) begin
            k = 2; p = (a - 4096) / 128; n = ((a - 4096) % 128) / 4;
        end else if (a >= 8192 && a < 8192 + 7 * 128 && a % 4 == 0 && (a - 8192) % 128 < 32) begin
            k = 3 + (a - 8192) / 128; p = ((a - 8192) % 128) / 4;
        end
    endtask

    task automatic compare_all(input string tag, input bit exp_v, input logic [31:0] exp_d);
        logic [255:0] eo, ee;
        for (int p = 0; p < 8; p++) begin
            eo[p*32 +: 32] = m_out[p];
            ee[p*32 +: 32] = m_dir[p];
        end
        chk(tag, "gpio_out", gpio_out, eo);
        chk(tag, "gpio_oe", gpio_oe, ee);
        chk(tag, "rsp_valid", {255'b0, rsp_valid}, {255'b0, exp_v});
        chk(tag, "rsp_rdata", {224'b0, rsp_rdata}, {224'b0, exp_d});
    endtask

    task automatic op(input bit v, input bit w, input int a, input logic [31:0] d, input string tag);
        int k, p, n;
        logic [31:0] er, l;
        cmd_valid = v; cmd_write = w; cmd_addr = a[13:0]; cmd_wdata = d;
        bdecode(a, k, p, n);
        er = '0;
        if (v && !w) begin
            l = lvl(p);
            case (k)
                1: er = {31'b0, l[n]};
                2: er = l[n] ? 32'hFFFF_FFFF : 32'h0;
                3: er = m_dir[p];
                4: er = m_mask[p];
                5: er = l;
                6: er = l & ~m_mask[p];
                default: er = '0;
            endcase
        end
        @(posedge clk);
        if (v && w) begin
            case (k)
                1: m_out[p][n] = d[0];
                2: m_out[p][n] = (d != 0);
                3: m_dir[p] = d;
                4: m_mask[p] = d;
                5: m_out[p] = d;
                6: m_out[p] = (m_out[p] & m_mask[p]) | (d & ~m_mask[p]);
                7: m_out[p] = m_out[p] | d;
                8: m_out[p] = m_out[p] & ~d;
                9: m_out[p] = m_out[p] ^ d;
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 0; cmd_write = 0; cmd_addr = '0; cmd_wdata = '0;
        compare_all(tag, v && !w, er);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        op(1, 1, a, d, tag);
    endtask

    task automatic rd(input int a, input string tag);
        op(1, 0, a, 32'h0, tag);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] seed;
        for (int p = 0; p < 8; p++) begin
            m_out[p] = '0; m_dir[p] = '0; m_mask[p] = '0;
        end
        // R1: outputs held at zero during and after reset
        repeat (3) @(negedge clk);
        compare_all("R1", 0, 32'h0);
        rst_n = 1'b1;
        op(0, 0, 0, 32'h0, "R1");
        rd(8192 + 5*4, "R1");
        rd(8192 + 128 + 5*4, "R1");
        rd(8192 + 256 + 5*4, "R1");

        // R3: direction register and output enables
        wr(8192 + 0*4, 32'h0000_FFFF, "R3");
        rd(8192 + 0*4, "R3");

        // R4/R5: mixed direction, whole-port access
        gpio_in[31:0] = 32'hA5A5_5A5A;
        wr(8192 + 256 + 0*4, 32'h1234_5678, "R5");
        rd(8192 + 256 + 0*4, "R4");
        gpio_in[31:0] = 32'h0F0F_F0F0;
        rd(8192 + 256 + 0*4, "R4");

        // R6: byte alias
        wr(8192 + 1*4, 32'hFFFF_FFFF, "R3");
        wr(32 + 3, 32'h0000_0001, "R6");
        rd(32 + 3, "R6");
        rd(32 + 4, "R6");
        wr(32 + 4, 32'h0000_00FE, "R6");
        rd(20, "R6");
        rd(5, "R6");

        // R7: word alias
        wr(8192 + 2*4, 32'hFFFF_FFFF, "R3");
        wr(4096 + 2*128 + 5*4, 32'h0000_0100, "R7");
        rd(4096 + 2*128 + 5*4, "R7");
        wr(4096 + 2*128 + 5*4, 32'h0, "R7");
        rd(4096 + 2*128 + 5*4, "R7");
        gpio_in[3*32 + 9] = 1'b1;
        rd(4096 + 3*128 + 9*4, "R7");

        // R8: mask and masked port
        wr(8192 + 128 + 2*4, 32'hFFFF_0000, "R8");
        rd(8192 + 128 + 2*4, "R8");
        wr(8192 + 256 + 2*4, 32'h8001_0000, "R8");
        wr(8192 + 384 + 2*4, 32'hFFFF_FFFF, "R8");
        rd(8192 + 384 + 2*4, "R8");
        rd(8192 + 256 + 2*4, "R8");

        // R9/R10: set, clear, invert
        wr(8192 + 3*4, 32'hFFFF_FFFF, "R3");
        wr(8192 + 512 + 3*4, 32'h0000_00F1, "R9");
        wr(8192 + 640 + 3*4, 32'h0000_0030, "R9");
        wr(8192 + 768 + 3*4, 32'h8000_0003, "R9");
        rd(8192 + 256 + 3*4, "R9");
        rd(8192 + 512 + 3*4, "R10");
        rd(8192 + 640 + 3*4, "R10");
        rd(8192 + 768 + 3*4, "R10");

        // R11: unmapped addresses
        wr(256, 32'hFFFF_FFFF, "R11");
        wr(8192 + 7*128, 32'hFFFF_FFFF, "R11");
        wr(8192 + 36, 32'hFFFF_FFFF, "R11");
        wr(8192 + 2, 32'hFFFF_FFFF, "R11");
        wr(4096 + 6, 32'hFFFF_FFFF, "R11");
        rd(256, "R11");
        rd(8192 + 7*128, "R11");
        rd(8192 + 36, "R11");
        rd(8192 + 258, "R11");
        rd(12288, "R11");

        // R2: back-to-back reads then idle
        rd(8192 + 0*4, "R2");
        rd(8192 + 256 + 1*4, "R2");
        op(0, 0, 0, 32'h0, "R2");
        wr(8192 + 256 + 4*4, 32'hDEAD_BEEF, "R2");

        // mixed pseudo-random traffic
        seed = 32'h1357_9BDF;
        for (int i = 0; i < 400; i++) begin
            int cls, a;
            logic [31:0] d;
            seed = seed * 32'd1664525 + 32'd1013904223;
            cls = int'(seed[31:28]) % 6;
            case (cls)
                0: a = int'(seed[19:12]);
                1: a = 4096 + int'(seed[19:12]) * 4;
                2, 3: a = 8192 + (int'(seed[18:16]) % 7) * 128 + int'(seed[14:12]) * 4;
                4: a = 8192 + int'(seed[14:12]) * 4;
                default: a = (seed[12]) ? 8192 + 40 : 300;
            endcase
            d = seed ^ {seed[15:0], seed[31:16]};
            if (seed[7:4] == 4'd0) gpio_in[int'(seed[10:8])*32 +: 32] = d;
            op(1, seed[25], a, d, "R4 R5 R8 R9 mixed");
        end

        done = 1;
        finish_run();
    end
endmodule